// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a two-part logical address, a segment number and an offset, into a physical address using a small segment table held in flops. Each table entry keeps a physical base, a length limit, a valid flag and three permission flags (read, write, execute). A length register sets how many segment numbers are legal. Each access is checked on three fronts: the segment number against the length register, the offset against the entry limit, and the access type against the entry flags. A failed check raises a trap with a 2-bit cause code instead of producing an address.

The table and the length register are loaded through a write port. This port only works while the kernel-mode input is high. A write attempted from user mode is dropped and flags a privilege error. Translation requests are captured on a clock edge. The response is formed combinationally from the captured request and the current table, so it appears one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid and priv_err are low, the length register is 0 and every entry is invalid, so any translation traps with cause 01.
- R2: A request presented with req_valid high at a clock edge is answered with rsp_valid high during the following cycle. With no request, rsp_valid is low, rsp_trap is low and rsp_cause is 00.
- R3: If no check fails, rsp_paddr equals entry base plus offset, modulo 2^PA_W, and rsp_cause is 00.
- R4: A segment number greater than or equal to the length register gives cause 01.
- R5: A segment whose valid flag is 0 gives cause 01.
- R6: An offset greater than or equal to the entry limit gives cause 10. An offset of limit minus 1 passes this check.
- R7: The access code selects the permission flag to check. Code 00 (read) checks perm bit 0, code 01 (write) checks perm bit 1, and code 10 (execute) checks perm bit 2. A clear bit gives cause 11, and code 11 always gives cause 11.
- R8: When several checks fail, the cause is picked by priority: 01 first, then 10, then 11.
- R9: rsp_trap is high exactly when rsp_cause is nonzero, and a trapped response drives rsp_paddr to 0.
- R10: A table write or length write presented while kmode is low leaves the table and length unchanged. priv_err is high during the cycle after such an attempt.
- R11: A kernel-mode table write and a request presented at the same edge: the response uses the newly written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kmode | input | 1 | High when the issuer runs in kernel mode |
| tw_en | input | 1 | Table entry write strobe |
| tw_idx | input | SEG_W | Entry index to write |
| tw_base | input | PA_W | Physical base for the entry |
| tw_limit | input | OFF_W+1 | Segment length limit for the entry |
| tw_valid | input | 1 | Valid flag for the entry |
| tw_perm | input | 3 | Permission flags: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Length register write strobe |
| len_val | input | SEG_W+1 | New number of legal segments |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access code: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_trap | output | 1 | Addressing trap |
| rsp_cause | output | 2 | 00 none, 01 segment bad, 10 offset over limit, 11 permission |
| priv_err | output | 1 | Previous cycle saw a write attempt from user mode |

## Verification
The assertions check four rules on every cycle: each request is answered in the next cycle and never otherwise, a trapped response carries no address, an idle response shows no cause, and a user-mode attempt raises priv_err and leaves the length register alone. Only the directed scenarios can show the rest. These cover the address sum and its wraparound, each trap cause at its exact boundary (offset equal to the limit, segment equal to the length), the priority among causes that fail together, and a user-mode table write that leaves an entry unchanged. They also show that a write and a request at the same edge see the new entry.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kmode,
  input  logic               tw_en,
  input  logic [SEG_W-1:0]   tw_idx,
  input  logic [PA_W-1:0]    tw_base,
  input  logic [OFF_W:0]     tw_limit,
  input  logic               tw_valid,
  input  logic [2:0]         tw_perm,
  input  logic               len_we,
  input  logic [SEG_W:0]     len_val,
  input  logic               req_valid,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_trap,
  output logic [1:0]         rsp_cause,
  output logic               priv_err
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int LIM_W = OFF_W + 1;

  logic [PA_W-1:0]  base_q [NSEG];
  logic [LIM_W-1:0] lim_q  [NSEG];
  logic [2:0]       perm_q [NSEG];
  logic [NSEG-1:0]  vld_q;
  logic [SEG_W:0]   len_q;

  logic             rq_v;
  logic [SEG_W-1:0] rq_seg;
  logic [OFF_W-1:0] rq_off;
  logic [1:0]       rq_acc;

  wire kw = tw_en & kmode;
  wire lw = len_we & kmode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        perm_q[i] <= '0;
      end
      vld_q    <= '0;
      len_q    <= '0;
      priv_err <= 1'b0;
    end else begin
      if (kw) begin
        base_q[tw_idx] <= tw_base;
        lim_q[tw_idx]  <= tw_limit;
        perm_q[tw_idx] <= tw_perm;
        vld_q[tw_idx]  <= tw_valid;
      end
      if (lw) len_q <= len_val;
      priv_err <= (tw_en | len_we) & ~kmode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_v   <= 1'b0;
      rq_seg <= '0;
      rq_off <= '0;
      rq_acc <= '0;
    end else begin
      rq_v <= req_valid;
      if (req_valid) begin
        rq_seg <= req_seg;
        rq_off <= req_off;
        rq_acc <= req_acc;
      end
    end
  end

  logic seg_ok, off_ok, perm_ok;
  logic [1:0] cause;

  assign seg_ok = ({1'b0, rq_seg} < len_q) && vld_q[rq_seg];
  assign off_ok = {1'b0, rq_off} < lim_q[rq_seg];

  always_comb begin
    unique case (rq_acc)
      2'b00:   perm_ok = perm_q[rq_seg][0];
      2'b01:   perm_ok = perm_q[rq_seg][1];
      2'b10:   perm_ok = perm_q[rq_seg][2];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!seg_ok)       cause = 2'b01;
    else if (!off_ok)  cause = 2'b10;
    else if (!perm_ok) cause = 2'b11;
    else               cause = 2'b00;
  end

  assign rsp_valid = rq_v;
  assign rsp_cause = rq_v ? cause : 2'b00;
  assign rsp_trap  = rq_v && (cause != 2'b00);
  assign rsp_paddr = (rq_v && cause == 2'b00) ? base_q[rq_seg] + PA_W'(rq_off) : '0;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_cause == 2'b00 && !rsp_trap)); // R2
  AST_TRAP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_paddr == '0); // R9
  AST_USER_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((tw_en || len_we) && !kmode) |=> priv_err); // R10
  AST_USER_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && !kmode) |=> $stable(len_q)); // R10
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        kmode = 0;
  logic        tw_en = 0;
  logic [2:0]  tw_idx = 0;
  logic [15:0] tw_base = 0;
  logic [12:0] tw_limit = 0;
  logic        tw_valid = 0;
  logic [2:0]  tw_perm = 0;
  logic        len_we = 0;
  logic [3:0]  len_val = 0;
  logic        req_valid = 0;
  logic [2:0]  req_seg = 0;
  logic [11:0] req_off = 0;
  logic [1:0]  req_acc = 0;
  logic        rsp_valid, rsp_trap, priv_err;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .kmode(kmode),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_base(tw_base), .tw_limit(tw_limit),
    .tw_valid(tw_valid), .tw_perm(tw_perm), .len_we(len_we), .len_val(len_val),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap),
    .rsp_cause(rsp_cause), .priv_err(priv_err));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic twr(input bit k, input [2:0] idx, input [15:0] b, input [12:0] l,
                     input bit v, input [2:0] p);
    @(negedge clk);
    kmode = k; tw_en = 1; tw_idx = idx; tw_base = b; tw_limit = l; tw_valid = v; tw_perm = p;
    @(negedge clk);
    tw_en = 0; kmode = 0;
  endtask

  task automatic lwr(input bit k, input [3:0] n);
    @(negedge clk);
    kmode = k; len_we = 1; len_val = n;
    @(negedge clk);
    len_we = 0; kmode = 0;
  endtask

  task automatic xl(input [2:0] s, input [11:0] d, input [1:0] a,
                    input [1:0] ec, input [15:0] epa, input string tag);
    @(negedge clk);
    req_valid = 1; req_seg = s; req_off = d; req_acc = a;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " cause"}, rsp_cause, ec);
    chk({tag, " trap"}, rsp_trap, ec != 0);
    chk({tag, " paddr"}, rsp_paddr, epa);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 priv_err after reset", priv_err, 0);
    xl(0, 0, 0, 2'b01, 0, "R1 empty table");
    @(negedge clk);
    chk("R2 idle rsp_valid", rsp_valid, 0);
    chk("R2 idle cause", rsp_cause, 0);
  endtask

  task automatic t_load;
    lwr(1, 4);
    twr(1, 0, 16'h1000, 13'h100, 1, 3'b011);
    twr(1, 1, 16'h7000, 13'h800, 1, 3'b100);
    twr(1, 2, 16'h2000, 13'h010, 0, 3'b111);
    twr(1, 3, 16'hFF00, 13'h1000, 1, 3'b001);
    twr(1, 5, 16'h5000, 13'h100, 1, 3'b111);
  endtask

  task automatic t_translate;
    xl(0, 12'h042, 0, 0, 16'h1042, "R3 read seg0");
    xl(1, 12'h7FF, 2, 0, 16'h77FF, "R3 exec seg1 last byte");
    xl(3, 12'h200, 0, 0, 16'h0100, "R3 wraparound");
  endtask

  task automatic t_ranges;
    xl(4, 12'h000, 0, 2'b01, 0, "R4 seg equals length");
    xl(5, 12'h000, 0, 2'b01, 0, "R4 seg above length");
    xl(2, 12'h001, 0, 2'b01, 0, "R5 invalid entry");
    xl(0, 12'h100, 0, 2'b10, 0, "R6 offset equals limit");
    xl(0, 12'h0FF, 1, 0, 16'h10FF, "R6 offset limit-1");
  endtask

  task automatic t_perm;
    xl(0, 12'h010, 2, 2'b11, 0, "R7 exec on rw segment");
    xl(1, 12'h010, 0, 2'b11, 0, "R7 read on exec segment");
    xl(1, 12'h010, 1, 2'b11, 0, "R7 write on exec segment");
    xl(3, 12'h010, 1, 2'b11, 0, "R7 write on read-only");
    xl(0, 12'h010, 3, 2'b11, 0, "R7 reserved code");
  endtask

  task automatic t_priority;
    xl(2, 12'hFFF, 3, 2'b01, 0, "R8 invalid beats offset and perm");
    xl(1, 12'hFFF, 0, 2'b10, 0, "R8 offset beats perm");
  endtask

  task automatic t_user;
    twr(0, 0, 16'h3000, 13'h010, 0, 3'b000);
    chk("R10 priv_err after user table write", priv_err, 1);
    lwr(0, 1);
    chk("R10 priv_err after user len write", priv_err, 1);
    xl(0, 12'h020, 1, 0, 16'h1020, "R10 entry unchanged");
    xl(3, 12'h000, 0, 0, 16'hFF00, "R10 length unchanged");
    chk("R10 priv_err clears", priv_err, 0);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    kmode = 1; tw_en = 1; tw_idx = 2; tw_base = 16'h4400; tw_limit = 13'h040;
    tw_valid = 1; tw_perm = 3'b010;
    req_valid = 1; req_seg = 2; req_off = 12'h03F; req_acc = 1;
    @(negedge clk);
    tw_en = 0; kmode = 0; req_valid = 0;
    chk("R11 same-edge cause", rsp_cause, 0);
    chk("R11 same-edge paddr", rsp_paddr, 16'h443F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_translate();
    t_ranges();
    t_perm();
    t_priority();
    t_user();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule